// File: doc/BRIEF.md
# Watchdog Register Front End with Unlock Sequence

This block is the register-side front end of a two-stage watchdog. It decodes a 16-byte little-endian memory window that accepts 1-, 2- and 4-byte accesses. It also decodes two registers in a separate configuration space. It produces preload values, control fields and single-cycle command pulses for a timer core that lives outside this block.

Every write that changes the timer's behaviour through the memory window is protected. Software must first write 0x80 and then 0x86 to offset 0x0C. That arms exactly one protected write, and the arming is spent as soon as that write lands. The configuration space holds a 16-bit control register and an 8-bit lock register. Once the lock bit is set, the lock register freezes until reset.

All register state and all pulses change on the clock edge that accepts the access. Read data is registered, so it appears one cycle after the read is accepted and holds until the next read.

Top module: `wdt_regfront`

## Requirements
- R1: After reset, both preloads are 0xFFFFF, reboot is enabled, fast clock is off, the interrupt type is 0, and enable, free-run and lock are clear. No pulse is active.
- R2: When the unlock is open, a 4-byte write to offset 0x00 loads the stage-1 preload from data bits 19:0. A 4-byte write to offset 0x04 loads the stage-2 preload from the same bits.
- R3: A protected write (preload load or keepalive) issued without the full unlock sequence changes no output.
- R4: When the unlock is open, the first write that is not a magic value consumes the unlock, whether or not it has any effect. A second such write has no effect.
- R5: Writing 0x86 to offset 0x0C when 0x80 was not the last magic step does not open the unlock.
- R6: When only 0x80 has been written, a write that is neither magic value keeps the machine waiting for 0x86 and has no other effect.
- R7: When the unlock is open, a 2-byte write to offset 0x0C pulses the keepalive for one cycle if bit 8 is set. It pulses the flag-clear for one cycle if bit 9 or bit 12 is set.
- R8: A 2-byte read of offset 0x0C returns 0x1200 while the previous-timeout flag input is high, and 0 otherwise. Every other memory read returns 0.
- R9: A 2-byte configuration write at offset 0x60 sets the fields as follows: bit 5 = reboot disable, bit 2 = fast clock, bits 1:0 = interrupt type. A 2-byte read returns the same layout. Accesses of any other size at 0x60 are ignored.
- R10: A 1-byte configuration write at offset 0x68 sets the fields as follows: bit 2 = free-run, bit 1 = enable, bit 0 = lock. A 1-byte read returns the same layout. While lock is set, writes to this register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cfg | input | 1 | 1 = configuration space, 0 = memory window |
| bus_addr | input | 8 | Byte offset |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| prev_timeout | input | 1 | Previous-timeout flag from the timer core |
| stage1_preload | output | 20 | First-stage reload value |
| stage2_preload | output | 20 | Second-stage reload value |
| kick | output | 1 | One-cycle keepalive pulse |
| flag_clr | output | 1 | One-cycle request to clear the previous-timeout flag |
| reboot_en | output | 1 | Reboot on second-stage expiry |
| fast_clk | output | 1 | Fast decrement clock select |
| int_type | output | 2 | First-stage interrupt type |
| wd_enable | output | 1 | Watchdog enable |
| free_run | output | 1 | Restart first stage after second-stage expiry |
| wd_locked | output | 1 | Lock register frozen |

## Verification
The hardest state to reach is the one where only 0x80 has been accepted and an unrelated write arrives. Nothing observable changes at that point, so the state can only be seen later. The stimulus sends 0x80, then a non-magic write, then 0x86, then a preload write. It checks that the preload loads. The opposite cases follow the same pattern: a lone 0x86 before a load, a wrongly sized protected write before a correct one, and a second load after a consumed unlock. Each of these must leave the preload unchanged.

// File: rtl/wdt_regfront.sv
module wdt_regfront #(
  parameter int PRELOAD_W = 20,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic                 bus_cfg,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 prev_timeout,
  output logic [PRELOAD_W-1:0] stage1_preload,
  output logic [PRELOAD_W-1:0] stage2_preload,
  output logic                 kick,
  output logic                 flag_clr,
  output logic                 reboot_en,
  output logic                 fast_clk,
  output logic [1:0]           int_type,
  output logic                 wd_enable,
  output logic                 free_run,
  output logic                 wd_locked
);
  localparam logic [1:0] SZ1 = 2'd0, SZ2 = 2'd1, SZ4 = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_T1 = ADDR_W'('h00), OFS_T2 = ADDR_W'('h04),
                                OFS_KEY = ADDR_W'('h0C), OFS_CFG = ADDR_W'('h60),
                                OFS_LCK = ADDR_W'('h68);
  localparam logic [DATA_W-1:0] KEY_A = DATA_W'('h80), KEY_B = DATA_W'('h86);

  typedef enum logic [1:0] {LK_IDLE, LK_ARMED, LK_OPEN} lk_t;
  lk_t ust;
  logic reboot_dis;
  logic [DATA_W-1:0] rd_mux;

  wire mem_wr  = bus_valid && bus_write && !bus_cfg;
  wire cfg_wr  = bus_valid && bus_write && bus_cfg;
  wire hit_key = bus_addr == OFS_KEY;
  wire is_a    = hit_key && bus_wdata == KEY_A;
  wire is_b    = hit_key && bus_wdata == KEY_B && ust == LK_ARMED;

  assign reboot_en = !reboot_dis;

  always_comb begin
    rd_mux = '0;
    if (bus_cfg) begin
      if (bus_addr == OFS_CFG && bus_size == SZ2) begin
        rd_mux[5]   = reboot_dis;
        rd_mux[2]   = fast_clk;
        rd_mux[1:0] = int_type;
      end else if (bus_addr == OFS_LCK && bus_size == SZ1) begin
        rd_mux[2] = free_run;
        rd_mux[1] = wd_enable;
        rd_mux[0] = wd_locked;
      end
    end else if (hit_key && bus_size == SZ2 && prev_timeout) begin
      rd_mux = DATA_W'('h1200);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ust            <= LK_IDLE;
      stage1_preload <= '1;
      stage2_preload <= '1;
      kick           <= 1'b0;
      flag_clr       <= 1'b0;
      reboot_dis     <= 1'b0;
      fast_clk       <= 1'b0;
      int_type       <= '0;
      wd_enable      <= 1'b0;
      free_run       <= 1'b0;
      wd_locked      <= 1'b0;
      bus_rdata      <= '0;
    end else begin
      kick     <= 1'b0;
      flag_clr <= 1'b0;
      if (mem_wr) begin
        if (is_a) ust <= LK_ARMED;
        else if (is_b) ust <= LK_OPEN;
        else if (ust == LK_OPEN) begin
          ust <= LK_IDLE;
          if (bus_size == SZ4 && bus_addr == OFS_T1) stage1_preload <= bus_wdata[PRELOAD_W-1:0];
          if (bus_size == SZ4 && bus_addr == OFS_T2) stage2_preload <= bus_wdata[PRELOAD_W-1:0];
          if (bus_size == SZ2 && hit_key) begin
            kick     <= bus_wdata[8];
            flag_clr <= bus_wdata[9] | bus_wdata[12];
          end
        end
      end
      if (cfg_wr && bus_addr == OFS_CFG && bus_size == SZ2) begin
        reboot_dis <= bus_wdata[5];
        fast_clk   <= bus_wdata[2];
        int_type   <= bus_wdata[1:0];
      end
      if (cfg_wr && bus_addr == OFS_LCK && bus_size == SZ1 && !wd_locked) begin
        wd_locked <= bus_wdata[0];
        wd_enable <= bus_wdata[1];
        free_run  <= bus_wdata[2];
      end
      if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end
  end

  // R7: pulses only follow an open unlock and cannot repeat back to back (R4)
  assert_kick_needs_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick || flag_clr) |-> $past(ust) == LK_OPEN);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
  // R3: preloads move only through an open unlock
  assert_preload_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(stage1_preload) && $stable(stage2_preload)) |-> $past(ust) == LK_OPEN);
  // R10: lock is sticky and freezes its siblings
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_locked |=> wd_locked && $stable({wd_enable, free_run}));
  // R5: the open state is entered only from the armed state
  assert_open_from_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ust == LK_OPEN) |-> $past(ust) == LK_ARMED);
endmodule

// File: tb/wdt_regfront_bench.sv
`timescale 1ns/100ps
module wdt_regfront_bench;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_cfg = 0, prev_timeout = 0;
  logic [7:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [19:0] stage1_preload, stage2_preload;
  logic kick, flag_clr, reboot_en, fast_clk, wd_enable, free_run, wd_locked;
  logic [1:0] int_type;
  int checks = 0, errors = 0;
  logic seen_kick, seen_clr;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  wdt_regfront u_wdt_regfront (.clk, .rst_n, .bus_valid, .bus_write, .bus_cfg, .bus_addr,
    .bus_size, .bus_wdata, .bus_rdata, .prev_timeout, .stage1_preload, .stage2_preload,
    .kick, .flag_clr, .reboot_en, .fast_clk, .int_type, .wd_enable, .free_run, .wd_locked);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(bit cfg, bit wr, logic [7:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_cfg = cfg; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0;
    seen_kick = kick; seen_clr = flag_clr; rd = bus_rdata;
  endtask

  task automatic unlock();
    access(0, 1, 8'h0C, 2'd0, 32'h80);
    access(0, 1, 8'h0C, 2'd2, 32'h86);
  endtask

  task automatic t_reset();
    check("R1 pre1", 32'(stage1_preload), 32'hFFFFF);
    check("R1 pre2", 32'(stage2_preload), 32'hFFFFF);
    check("R1 ctrl", {reboot_en, fast_clk, int_type, wd_enable, free_run, wd_locked, kick, flag_clr},
          32'b1000_0000_0);
  endtask

  task automatic t_preload();
    unlock(); access(0, 1, 8'h00, 2'd2, 32'hABCDE123);
    check("R2 pre1", 32'(stage1_preload), 32'hDE123);
    unlock(); access(0, 1, 8'h04, 2'd2, 32'h00012345);
    check("R2 pre2", 32'(stage2_preload), 32'h12345);
  endtask

  task automatic t_guard();
    access(0, 1, 8'h00, 2'd2, 32'h11111);
    check("R3 no unlock", 32'(stage1_preload), 32'hDE123);
    access(0, 1, 8'h0C, 2'd1, 32'h0100);
    check("R3 no kick", 32'(seen_kick), 0);
    access(0, 1, 8'h0C, 2'd2, 32'h86);
    access(0, 1, 8'h00, 2'd2, 32'h22222);
    check("R5 lone 0x86", 32'(stage1_preload), 32'hDE123);
  endtask

  task automatic t_consume();
    unlock(); access(0, 1, 8'h04, 2'd2, 32'h22222);
    access(0, 1, 8'h04, 2'd2, 32'h33333);
    check("R4 second write", 32'(stage2_preload), 32'h22222);
    unlock(); access(0, 1, 8'h00, 2'd1, 32'h5555);
    check("R4 wrong size", 32'(stage1_preload), 32'hDE123);
    access(0, 1, 8'h00, 2'd2, 32'h66666);
    check("R4 consumed", 32'(stage1_preload), 32'hDE123);
  endtask

  task automatic t_armed_hold();
    access(0, 1, 8'h0C, 2'd1, 32'h80);
    access(0, 1, 8'h08, 2'd1, 32'h5555);
    check("R6 no effect", 32'(stage1_preload), 32'hDE123);
    access(0, 1, 8'h0C, 2'd2, 32'h86);
    access(0, 1, 8'h00, 2'd2, 32'h44444);
    check("R6 still armed", 32'(stage1_preload), 32'h44444);
  endtask

  task automatic t_pulses();
    unlock(); access(0, 1, 8'h0C, 2'd1, 32'h0100);
    check("R7 kick", {seen_kick, seen_clr}, 32'b10);
    @(negedge clk);
    check("R7 kick one cycle", 32'(kick), 0);
    unlock(); access(0, 1, 8'h0C, 2'd1, 32'h0200);
    check("R7 clr bit9", {seen_kick, seen_clr}, 32'b01);
    unlock(); access(0, 1, 8'h0C, 2'd1, 32'h1000);
    check("R7 clr bit12", {seen_kick, seen_clr}, 32'b01);
  endtask

  task automatic t_read();
    prev_timeout = 1;
    access(0, 0, 8'h0C, 2'd1, 0); check("R8 flag set", rd, 32'h1200);
    access(0, 0, 8'h0C, 2'd2, 0); check("R8 wide read", rd, 0);
    access(0, 0, 8'h00, 2'd1, 0); check("R8 other offset", rd, 0);
    prev_timeout = 0;
    access(0, 0, 8'h0C, 2'd1, 0); check("R8 flag clear", rd, 0);
  endtask

  task automatic t_cfg();
    access(1, 1, 8'h60, 2'd1, 32'h0027);
    check("R9 fields", {reboot_en, fast_clk, int_type}, 32'b0111);
    access(1, 0, 8'h60, 2'd1, 0); check("R9 readback", rd, 32'h27);
    access(1, 1, 8'h60, 2'd0, 32'h0000);
    check("R9 byte ignored", {reboot_en, fast_clk, int_type}, 32'b0111);
  endtask

  task automatic t_lock();
    access(1, 1, 8'h68, 2'd0, 32'h06);
    check("R10 fields", {free_run, wd_enable, wd_locked}, 32'b110);
    access(1, 1, 8'h68, 2'd0, 32'h07);
    access(1, 1, 8'h68, 2'd0, 32'h00);
    check("R10 locked", {free_run, wd_enable, wd_locked}, 32'b111);
    access(1, 0, 8'h68, 2'd0, 0); check("R10 readback", rd, 32'h07);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset(); t_preload(); t_guard(); t_consume(); t_armed_hold();
    t_pulses(); t_read(); t_cfg(); t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule